// File: doc/BRIEF.md
# Retriggerable Lock Detector

This block judges whether a phase-lock loop has settled by watching the pulses that the loop's search circuitry produces while it hunts for a lock point. Each new search pulse restarts a digital timeout counter. As long as pulses keep coming faster than the timeout, the counter never runs out and the block reports that the loop is still searching. Once the pulses stop and the counter runs out, the block reports lock.

Two outputs come from the same timeout. The first is a lock status bit that the host samples whenever it wants. The second is an inhibit that freezes the up/down service-request lines while the timer is running and frees them once it has expired. The search input may be asynchronous to the clock. It passes through a synchronizer chain of parameterized depth, and only its rising transitions retrigger the timer.

Top module: `lock_sense`

## Requirements
- R1: While `rst_n` is low, `lock_o` is 0 and `hold_o` is 1.
- R2: After reset is released with `search_in` held low, `lock_o` stays 0 through the first TIMEOUT-1 rising clock edges. It reads 1 after the TIMEOUT-th rising edge.
- R3: A 0-to-1 transition of `search_in` first sampled at clock edge k restarts the timeout at edge k+SYNC_STAGES. After that edge `lock_o` is 0. If no further transition arrives, `lock_o` becomes 1 after edge k+SYNC_STAGES+TIMEOUT.
- R4: When successive restarts fall at most TIMEOUT edges apart, `lock_o` never rises between them. When they are spaced further apart, `lock_o` rises TIMEOUT edges after each restart.
- R5: A single transition arriving while `lock_o` is 1 leaves `lock_o` at 1 up to edge k+SYNC_STAGES. It drops `lock_o` to 0 right after that edge.
- R6: `hold_o` is at all times the inverse of `lock_o`. It falls only when the timeout runs out.
- R7: Only rising transitions retrigger. A `search_in` level held high restarts the timeout once, and lock is then reached TIMEOUT edges later even though the input stays high.
- R8: Asserting reset in the middle of operation returns the outputs to the R1 state at once. After release, timing starts again as in R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| search_in | input | 1 | Search-activity pulse train, asynchronous |
| lock_o | output | 1 | Lock status bit for the host (1 = locked) |
| hold_o | output | 1 | Inhibit for the up/down service-request lines (1 = held) |

## Verification
A transition on `search_in` takes effect SYNC_STAGES+1 clock edges after the bench drives it on a falling edge. The extra edge comes from the first synchronizer sample. The outputs react to the timer combinationally, so a restart shows on `lock_o` right after its load edge, and lock appears TIMEOUT edges after the most recent load. The bench keeps a list of predicted load edges and derives the expected state of both outputs from the edge count since the latest load that has already taken effect. It compares both outputs on every falling edge. This means the exact cycle of each rise and each fall is checked, not just the settled value.

// File: rtl/lock_sense_pkg.sv
package lock_sense_pkg;

  // Bits needed to hold the values 0..span.
  function automatic int count_bits(int unsigned span);
    return (span < 1) ? 1 : $clog2(span + 1);
  endfunction

  // Next value of the retriggerable down-counter.
  function automatic int unsigned next_count(int unsigned cur, bit trig, int unsigned span);
    if (trig) return span;
    if (cur != 0) return cur - 1;
    return 0;
  endfunction

  // Timer idle (expired) test.
  function automatic bit is_expired(int unsigned cur);
    return cur == 0;
  endfunction

endpackage

// File: rtl/lock_sense_sync.sv
module lock_sense_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise_o
);
  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[0] <= 1'b0;
          else        chain_q[0] <= din;
        end
      end else begin : g_rest
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[i] <= 1'b0;
          else        chain_q[i] <= chain_q[i-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= chain_q[STAGES-1];
  end

  assign rise_o = chain_q[STAGES-1] & ~prev_q;

  // R7: a detected edge lasts one cycle, so a held level cannot retrigger again
  p_rise_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> !rise_o);

endmodule

// File: rtl/lock_sense_timer.sv
module lock_sense_timer
  import lock_sense_pkg::*;
#(
  parameter int unsigned SPAN = 1000,
  localparam int CW = count_bits(SPAN)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig_i,
  output logic active_o,
  output logic expire_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= CW'(SPAN);
    else        cnt_q <= CW'(next_count(32'(cnt_q), trig_i, SPAN));
  end

  assign active_o = !is_expired(32'(cnt_q));
  // Event: the counter reaches zero at the coming edge.
  assign expire_o = (cnt_q == CW'(1)) && !trig_i;

  // R3: every trigger reloads the full span
  p_reload_r3: assert property (@(posedge clk) disable iff (!rst_n)
    trig_i |=> cnt_q == CW'(SPAN));

  // R2: without a trigger a running counter steps down by one
  p_countdown_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!trig_i && cnt_q != '0) |=> cnt_q == CW'($past(cnt_q) - 1'b1));

  // R4: counter never exceeds the span
  p_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(SPAN));

endmodule

// File: rtl/lock_sense_status.sv
module lock_sense_status (
  input  logic active_i,
  output logic lock_o,
  output logic hold_o
);
  assign lock_o = ~active_i;
  assign hold_o = active_i;
endmodule

// File: rtl/lock_sense.sv
module lock_sense #(
  parameter int unsigned TIMEOUT     = 1000,
  parameter int          SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic search_in,
  output logic lock_o,
  output logic hold_o
);
  logic rise_w;
  logic active_w;
  logic expire_w;

  lock_sense_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .din    (search_in),
    .rise_o (rise_w)
  );

  lock_sense_timer #(.SPAN(TIMEOUT)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .trig_i   (rise_w),
    .active_o (active_w),
    .expire_o (expire_w)
  );

  lock_sense_status u_status (
    .active_i (active_w),
    .lock_o   (lock_o),
    .hold_o   (hold_o)
  );

  // R2: lock appears only when the timer runs out
  p_lock_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock_o) |-> $past(expire_w));

  // R5: lock is lost only through a detected search edge
  p_lock_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lock_o) |-> $past(rise_w));

  // R4: once locked, lock persists until a search edge
  p_lock_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_o && !rise_w) |=> lock_o);

  // R6: the inhibit is released only at timeout
  p_hold_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hold_o) |-> $past(expire_w));

endmodule

// File: tb/lock_sense_tb.sv
module lock_sense_tb;
  localparam int T = 8;
  localparam int S = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic search_in = 1'b0;
  logic lock_o, hold_o;

  int cyc = 0;
  int tests = 0;
  int fails = 0;
  int loads[$];
  bit finished = 1'b0;

  always #10 clk = ~clk;

  lock_sense #(.TIMEOUT(T), .SYNC_STAGES(S)) u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .search_in (search_in),
    .lock_o    (lock_o),
    .hold_o    (hold_o)
  );

  always @(posedge clk) begin
    if (!rst_n) cyc <= 0;
    else        cyc <= cyc + 1;
  end

  // Expected lock: TIMEOUT edges elapsed since the latest load already in effect.
  function automatic bit exp_lock();
    int eff = 0;
    foreach (loads[i]) if (loads[i] <= cyc) eff = loads[i];
    return (cyc - eff) >= T;
  endfunction

  task automatic check(string tag, logic act, logic exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %0b expected %0b at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  task automatic check_now(string tag);
    bit e = exp_lock();
    if (!rst_n) e = 1'b0;
    check(tag, lock_o, e);
    check("R6", hold_o, !e);
  endtask

  task automatic run(int n, string tag);
    repeat (n) begin
      @(negedge clk);
      check_now(tag);
    end
  endtask

  // Called at a falling edge; a 0->1 change loads at edge cyc+1+S.
  task automatic set_search(bit v);
    if (v && !search_in) loads.push_back(cyc + 1 + S);
    search_in = v;
  endtask

  task automatic pulse(int width, string tag);
    set_search(1'b1);
    run(width, tag);
    set_search(1'b0);
  endtask

  initial begin
    loads.push_back(0);
    run(3, "R1");
    rst_n = 1'b1;
    // R2: first lock after exactly T edges
    run(T + 4, "R2");
    // R5: single pulse while locked
    pulse(1, "R5");
    run(T + S + 3, "R5");
    // R4: sweep of restart spacings around the timeout
    for (int d = 2; d <= T + 3; d++) begin
      repeat (5) begin
        pulse(1, "R4");
        run(d - 1, "R4");
      end
      run(T + 3, "R4");
    end
    // R3: wider pulse, then quiet
    pulse(3, "R3");
    run(T + S + 3, "R3");
    // R7: level held high retriggers once
    set_search(1'b1);
    run(3 * T, "R7");
    set_search(1'b0);
    run(T + S + 2, "R7");
    // R8: reset while locked, then timing restarts
    rst_n = 1'b0;
    loads.delete();
    loads.push_back(0);
    run(3, "R8");
    rst_n = 1'b1;
    run(T + 3, "R8");
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!finished) begin
      tests++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion at cycle %0d", cyc);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule